// File: doc/BRIEF.md
# Sliding-Window Operand Read Buffer Controller

This controller decides when reads from a systolic array are served by an on-chip operand buffer that is fed from a slower backing memory. The operand sequence is held as a ring of lines, and each line is a small group of element addresses. Two circular windows of line indices slide over that ring. The resident window answers lookups. The refill window lies just ahead of it and is being loaded from backing memory. A percentage parameter sets an uneven split of capacity between the two windows.

Each request carries an address and the cycle at which it arrived. The controller tests the address against every line in the resident window in parallel. On a miss, it moves both windows forward by the refill line count and charges one backing-memory transfer. It repeats this until the address is resident. Response timing is computed arithmetically. A running offset, added to the arrival cycle, starts at the hit latency. After a miss the offset is reset so that the response lands on the completion cycle of the last transfer. The very first request after reset first fills the resident window, and that fill is timed to finish one cycle before the request arrived.

The operand table is written through a simple slot-write port before traffic starts. Requests use a valid/ready handshake. Each answer is a one-cycle pulse that carries the ready cycle and a flag marking whether any transfer was needed. A counter reports the total number of words requested from backing memory.

Top module: `dbuf_read_ctrl`

## Requirements
- R1: Sizing is derived as follows. Elements per line is ceil(TOTAL_ELEMS/100). Resident capacity is ceil(TOTAL_ELEMS*ACT_PCT/100) elements, and refill capacity is the rest. Resident line count A is min(NUM_LINES, ceil(resident capacity/line elements)). Refill line count P is min(NUM_LINES−A, ceil(refill capacity/line elements)). With the defaults this gives 2, 45 and 15. The first non-empty request after reset performs an initial fill. The fill places the resident window on lines [0, A), adds A*line-elements words (90) to `words_req`, and completes at arrival−1.
- R2: An address hits when some slot of a line inside the resident window holds it. When the window start is not below its end, the window wraps: it covers lines from start to the last line, and then line 0 up to end−1.
- R3: Every miss moves the window start forward by P modulo NUM_LINES. The end becomes start+A modulo NUM_LINES, and the refill window begins at the new end.
- R4: A miss triggers further refills until the address is resident. Each refill adds P*line-elements words (30) to `words_req`, and its completion cycle is the previous completion plus P plus MEM_LAT. A hit adds no words.
- R5: `rsp_cycle` equals `req_cycle` plus the running offset, and after reset the offset is HIT_LAT. All arithmetic is modulo 2^CYC_W.
- R6: After any refill, the offset becomes the last completion cycle minus the arrival cycle, so that response reports the completion cycle. The new offset then applies to later hits.
- R7: `rsp_miss` is 1 exactly when the request needed at least one refill.
- R8: A request whose address is all ones marks an empty slot. It is accepted and dropped: no response is produced, no words are counted, and `req_ready` stays high.
- R9: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the answer. Let F be 1 when a fill is needed and 0 otherwise, and let K be the number of refills. `rsp_valid` is a one-cycle pulse after rising edge 1+F+K counted from the accepting edge.
- R10: A synchronous active-high `rst` sets `req_ready` to 1, `rsp_valid` to 0 and `words_req` to 0. It empties the resident window, so the next request repeats the initial fill.
- R11: When `tbl_we` is high, a rising edge writes `tbl_addr` into slot `tbl_elem` of line `tbl_line`, and later lookups use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Operand table slot write enable |
| tbl_line | input | $clog2(NUM_LINES) | Line index of the slot written |
| tbl_elem | input | max(1,$clog2(line elements)) | Element index within the line |
| tbl_addr | input | ADDR_W | Address value stored in the slot |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Requested address; all ones marks an empty slot |
| req_cycle | input | CYC_W | Arrival cycle of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_cycle | output | CYC_W | Cycle at which the data is ready |
| rsp_miss | output | 1 | Request needed at least one refill |
| words_req | output | WORD_W | Total words requested from backing memory |

## Verification
The window test and the window advance share one lookup cycle. A miss rotates the pointers on the same edge that the next comparison will read. If the wrap decision were made on stale pointers, the error would show only in later requests. The bench provokes this with ascending, descending and strided sweeps over every stored address. These sweeps drive the window across the line-0 boundary many times, and the initial fill is merged with a refill on the first request after a reset. An independent arithmetic model of the windows judges each answer by its ready cycle, its miss flag, the word total and the number of cycles it took.

// File: rtl/dbuf_rd_pkg.sv
package dbuf_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_LOOK = 2'd2
    } phase_e;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned line_elems(input int unsigned total);
        return cdiv(total, 100);
    endfunction

    function automatic int unsigned act_cap(input int unsigned total, input int unsigned pct);
        return cdiv(total * pct, 100);
    endfunction

    function automatic int unsigned act_lines(input int unsigned total, input int unsigned pct,
                                              input int unsigned lines);
        int unsigned most;
        most = cdiv(act_cap(total, pct), line_elems(total));
        return (lines > most) ? most : lines;
    endfunction

    function automatic int unsigned pre_lines(input int unsigned total, input int unsigned pct,
                                              input int unsigned lines);
        int unsigned most;
        int unsigned left;
        most = cdiv(total - act_cap(total, pct), line_elems(total));
        left = lines - act_lines(total, pct, lines);
        return (left > most) ? most : left;
    endfunction

endpackage

// File: rtl/dbuf_line_cam.sv
module dbuf_line_cam #(
    parameter int NUM_LINES  = 64,
    parameter int LINE_ELEMS = 2,
    parameter int ADDR_W     = 16,
    parameter int LINE_W     = 6,
    parameter int ELEM_W     = 1
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [LINE_W-1:0]    wr_line,
    input  logic [ELEM_W-1:0]    wr_elem,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ADDR_W-1:0]    key,
    output logic [NUM_LINES-1:0] line_hit
);

    logic [ADDR_W-1:0] slot_q [NUM_LINES][LINE_ELEMS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_line][wr_elem] <= wr_addr;
        end
    end

    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
        logic [LINE_ELEMS-1:0] eq;
        for (genvar ge = 0; ge < LINE_ELEMS; ge++) begin : g_elem
            assign eq[ge] = (slot_q[gl][ge] == key);
        end
        assign line_hit[gl] = |eq;
    end

endmodule

// File: rtl/dbuf_window.sv
module dbuf_window #(
    parameter int NUM_LINES = 64,
    parameter int ACT_LINES = 45,
    parameter int PRE_LINES = 15,
    parameter int LINE_W    = 6
) (
    input  logic [LINE_W-1:0]    start,
    input  logic [LINE_W-1:0]    stop,
    output logic [NUM_LINES-1:0] resident,
    output logic [LINE_W-1:0]    nxt_start,
    output logic [LINE_W-1:0]    nxt_stop
);

    localparam int SUM_W = LINE_W + 1;

    function automatic logic [LINE_W-1:0] ring_add(input logic [LINE_W-1:0] base,
                                                   input int unsigned step);
        logic [SUM_W-1:0] sum;
        sum = {1'b0, base} + SUM_W'(step);
        if (sum >= SUM_W'(NUM_LINES)) begin
            sum = sum - SUM_W'(NUM_LINES);
        end
        return sum[LINE_W-1:0];
    endfunction

    always_comb begin
        nxt_start = ring_add(start, PRE_LINES);
        nxt_stop  = ring_add(nxt_start, ACT_LINES);
    end

    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_mask
        logic above_start;
        logic below_stop;
        assign above_start  = (LINE_W'(gl) >= start);
        assign below_stop   = (LINE_W'(gl) < stop);
        assign resident[gl] = (start < stop) ? (above_start && below_stop)
                                             : (above_start || below_stop);
    end

endmodule

// File: rtl/dbuf_backing.sv
module dbuf_backing #(
    parameter int CYC_W      = 32,
    parameter int WORD_W     = 32,
    parameter int ACT_LINES  = 45,
    parameter int PRE_LINES  = 15,
    parameter int LINE_ELEMS = 2,
    parameter int MEM_LAT    = 10
) (
    input  logic              fill,
    input  logic [CYC_W-1:0]  prev_done,
    input  logic [CYC_W-1:0]  arrival,
    output logic [CYC_W-1:0]  done,
    output logic [WORD_W-1:0] words
);

    localparam int FILL_WORDS = ACT_LINES * LINE_ELEMS;
    localparam int PRE_WORDS  = PRE_LINES * LINE_ELEMS;
    localparam int PRE_SPAN   = PRE_LINES + MEM_LAT;

    always_comb begin
        if (fill) begin
            done  = arrival - CYC_W'(1);
            words = WORD_W'(FILL_WORDS);
        end else begin
            done  = prev_done + CYC_W'(PRE_SPAN);
            words = WORD_W'(PRE_WORDS);
        end
    end

endmodule

// File: rtl/dbuf_read_ctrl.sv
module dbuf_read_ctrl
    import dbuf_rd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_LINES   = 64,
    parameter int TOTAL_ELEMS = 120,
    parameter int ACT_PCT     = 75,
    parameter int HIT_LAT     = 2,
    parameter int MEM_LAT     = 10,
    parameter int CYC_W       = 32,
    parameter int WORD_W      = 32,
    localparam int LINE_ELEMS = int'(line_elems(TOTAL_ELEMS)),
    localparam int LINE_W     = $clog2(NUM_LINES),
    localparam int ELEM_W     = (LINE_ELEMS > 1) ? $clog2(LINE_ELEMS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [LINE_W-1:0] tbl_line,
    input  logic [ELEM_W-1:0] tbl_elem,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CYC_W-1:0]  req_cycle,
    output logic              rsp_valid,
    output logic [CYC_W-1:0]  rsp_cycle,
    output logic              rsp_miss,
    output logic [WORD_W-1:0] words_req
);

    localparam int ACT_LINES = int'(act_lines(TOTAL_ELEMS, ACT_PCT, NUM_LINES));
    localparam int PRE_LINES = int'(pre_lines(TOTAL_ELEMS, ACT_PCT, NUM_LINES));

    typedef struct packed {
        phase_e             phase;
        logic [LINE_W-1:0]  start;
        logic [LINE_W-1:0]  stop;
        logic               full;
        logic [CYC_W-1:0]   offset;
        logic [CYC_W-1:0]   done;
        logic [WORD_W-1:0]  words;
        logic [ADDR_W-1:0]  key;
        logic [CYC_W-1:0]   arrival;
        logic               missed;
        logic               rv;
        logic [CYC_W-1:0]   rc;
        logic               rm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_LINES-1:0] line_hit;
    logic [NUM_LINES-1:0] resident;
    logic [LINE_W-1:0]    nxt_start;
    logic [LINE_W-1:0]    nxt_stop;
    logic [CYC_W-1:0]     bk_done;
    logic [WORD_W-1:0]    bk_words;
    logic                 fill_sel;
    logic                 found;
    logic [CYC_W-1:0]     off_new;
    logic [LINE_W-1:0]    win_start;
    logic                 win_full;

    dbuf_line_cam #(
        .NUM_LINES (NUM_LINES),
        .LINE_ELEMS(LINE_ELEMS),
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .ELEM_W    (ELEM_W)
    ) u_cam (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_line (tbl_line),
        .wr_elem (tbl_elem),
        .wr_addr (tbl_addr),
        .key     (ctl_q.key),
        .line_hit(line_hit)
    );

    dbuf_window #(
        .NUM_LINES(NUM_LINES),
        .ACT_LINES(ACT_LINES),
        .PRE_LINES(PRE_LINES),
        .LINE_W   (LINE_W)
    ) u_win (
        .start    (ctl_q.start),
        .stop     (ctl_q.stop),
        .resident (resident),
        .nxt_start(nxt_start),
        .nxt_stop (nxt_stop)
    );

    dbuf_backing #(
        .CYC_W     (CYC_W),
        .WORD_W    (WORD_W),
        .ACT_LINES (ACT_LINES),
        .PRE_LINES (PRE_LINES),
        .LINE_ELEMS(LINE_ELEMS),
        .MEM_LAT   (MEM_LAT)
    ) u_bk (
        .fill     (fill_sel),
        .prev_done(ctl_q.done),
        .arrival  (ctl_q.arrival),
        .done     (bk_done),
        .words    (bk_words)
    );

    assign fill_sel = (ctl_q.phase == PH_FILL);
    assign found    = |(line_hit & resident);
    assign off_new  = ctl_q.done - ctl_q.arrival;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.rv = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req_valid && (req_addr != '1)) begin
                    ctl_d.key     = req_addr;
                    ctl_d.arrival = req_cycle;
                    ctl_d.missed  = 1'b0;
                    ctl_d.phase   = ctl_q.full ? PH_LOOK : PH_FILL;
                end
            end
            PH_FILL: begin
                ctl_d.start = '0;
                ctl_d.stop  = LINE_W'(ACT_LINES);
                ctl_d.done  = bk_done;
                ctl_d.words = ctl_q.words + bk_words;
                ctl_d.full  = 1'b1;
                ctl_d.phase = PH_LOOK;
            end
            PH_LOOK: begin
                if (found) begin
                    if (ctl_q.missed) begin
                        ctl_d.offset = off_new;
                    end
                    ctl_d.rv    = 1'b1;
                    ctl_d.rm    = ctl_q.missed;
                    ctl_d.rc    = ctl_q.arrival + ctl_d.offset;
                    ctl_d.phase = PH_IDLE;
                end else begin
                    ctl_d.start  = nxt_start;
                    ctl_d.stop   = nxt_stop;
                    ctl_d.done   = bk_done;
                    ctl_d.words  = ctl_q.words + bk_words;
                    ctl_d.missed = 1'b1;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.phase   <= PH_IDLE;
            ctl_q.start   <= '0;
            ctl_q.stop    <= '0;
            ctl_q.full    <= 1'b0;
            ctl_q.offset  <= CYC_W'(HIT_LAT);
            ctl_q.done    <= '0;
            ctl_q.words   <= '0;
            ctl_q.key     <= '0;
            ctl_q.arrival <= '0;
            ctl_q.missed  <= 1'b0;
            ctl_q.rv      <= 1'b0;
            ctl_q.rc      <= '0;
            ctl_q.rm      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.phase == PH_IDLE);
    assign rsp_valid = ctl_q.rv;
    assign rsp_cycle = ctl_q.rc;
    assign rsp_miss  = ctl_q.rm;
    assign words_req = ctl_q.words;
    assign win_start = ctl_q.start;
    assign win_full  = ctl_q.full;

endmodule

// File: rtl/dbuf_read_ctrl_chk.sv
module dbuf_read_ctrl_chk
    import dbuf_rd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_LINES   = 64,
    parameter int TOTAL_ELEMS = 120,
    parameter int ACT_PCT     = 75,
    parameter int LINE_W      = 6,
    parameter int WORD_W      = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [WORD_W-1:0] words_req,
    input logic [LINE_W-1:0] win_start,
    input logic              win_full
);

    localparam int LE      = int'(line_elems(TOTAL_ELEMS));
    localparam int A_LINES = int'(act_lines(TOTAL_ELEMS, ACT_PCT, NUM_LINES));
    localparam int P_LINES = int'(pre_lines(TOTAL_ELEMS, ACT_PCT, NUM_LINES));
    localparam logic [WORD_W-1:0] FILL_STEP = WORD_W'(A_LINES * LE);
    localparam logic [WORD_W-1:0] PRE_STEP  = WORD_W'(P_LINES * LE);

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_addr != '1)) |=> !req_ready); // R9

    AST_EMPTY_SLOT_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_addr == '1)) |=> (req_ready && !rsp_valid && $stable(words_req))); // R8

    AST_NO_WORDS_ON_ANSWER: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $stable(words_req)); // R4

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(words_req)) |->
            (((words_req - $past(words_req)) == FILL_STEP) ||
             ((words_req - $past(words_req)) == PRE_STEP))); // R1

    AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (rst)
        (win_full && $past(win_full) && (win_start != $past(win_start))) |->
            (32'(win_start) == ((32'($past(win_start)) + P_LINES) % NUM_LINES))); // R3

    AST_START_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(win_start) < NUM_LINES); // R3

endmodule

bind dbuf_read_ctrl dbuf_read_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_LINES  (NUM_LINES),
    .TOTAL_ELEMS(TOTAL_ELEMS),
    .ACT_PCT    (ACT_PCT),
    .LINE_W     (LINE_W),
    .WORD_W     (WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .words_req(words_req),
    .win_start(win_start),
    .win_full (win_full)
);

// File: tb/tb_dbuf_read_ctrl.sv
module tb_dbuf_read_ctrl;

    localparam int LINES  = 64;
    localparam int ACT    = 45;
    localparam int PRE    = 15;
    localparam int LE     = 2;
    localparam int MEMLAT = 10;
    localparam int HITLAT = 2;
    localparam logic [15:0] BASE    = 16'h0100;
    localparam logic [15:0] SPECIAL = 16'h0F00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_line = '0;
    logic [0:0]  tbl_elem = '0;
    logic [15:0] tbl_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [31:0] req_cycle = '0;
    logic        rsp_valid;
    logic [31:0] rsp_cycle;
    logic        rsp_miss;
    logic [31:0] words_req;

    always #4 clk = ~clk;

    dbuf_read_ctrl #(
        .ADDR_W(16), .NUM_LINES(64), .TOTAL_ELEMS(120), .ACT_PCT(75),
        .HIT_LAT(2), .MEM_LAT(10), .CYC_W(32), .WORD_W(32)
    ) dut (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_line(tbl_line), .tbl_elem(tbl_elem),
        .tbl_addr(tbl_addr), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cycle(req_cycle), .rsp_valid(rsp_valid), .rsp_cycle(rsp_cycle), .rsp_miss(rsp_miss),
        .words_req(words_req)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit          m_full;
    int          m_start, m_stop;
    logic [31:0] m_done, m_off, m_words;
    logic [31:0] now_cyc = 32'd100;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input int l);
        if (m_start < m_stop) return (l >= m_start) && (l < m_stop);
        return (l >= m_start) || (l < m_stop);
    endfunction

    function automatic int line_of(input logic [15:0] a);
        if (a == SPECIAL) return 5;
        return int'(a - BASE) / 2;
    endfunction

    task automatic model_reset();
        m_full = 0; m_start = 0; m_stop = 0;
        m_done = '0; m_off = 32'(HITLAT); m_words = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R10 ready", 32'(req_ready), 32'd1);
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 words", words_req, 32'd0);
    endtask

    task automatic drive(input logic [15:0] a, input logic [31:0] cyc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_cycle = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic serve(input logic [15:0] a);
        int line, rot, fill, n;
        bit wrapped;
        logic [31:0] exp_cyc, cyc;
        cyc = now_cyc;
        now_cyc += 3;
        line = line_of(a);
        fill = 0;
        rot = 0;
        if (!m_full) begin
            fill = 1; m_full = 1; m_start = 0; m_stop = ACT;
            m_done = cyc - 32'd1;
            m_words += 32'(ACT * LE);
        end
        while (!in_win(line)) begin
            m_start = (m_start + PRE) % LINES;
            m_stop  = (m_start + ACT) % LINES;
            m_done += 32'(PRE + MEMLAT);
            m_words += 32'(PRE * LE);
            rot++;
        end
        wrapped = (m_start >= m_stop);
        if (rot > 0) m_off = m_done - cyc;
        exp_cyc = cyc + m_off;
        drive(a, cyc);
        n = 1;
        while (!rsp_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk((rot > 0) ? "R6 cycle" : "R5 cycle", rsp_cycle, exp_cyc);
        chk((rot > 0) ? "R3 miss" : (wrapped ? "R2 miss" : "R7 miss"), 32'(rsp_miss), 32'(rot > 0));
        chk((fill == 1 && rot == 0) ? "R1 words" : "R4 words", words_req, m_words);
        chk("R9 latency", 32'(n), 32'(2 + fill + rot));
        @(negedge clk);
        chk("R9 pulse", 32'(rsp_valid), 32'd0);
    endtask

    task automatic skip_req();
        drive(16'hFFFF, now_cyc);
        chk("R8 ready", 32'(req_ready), 32'd1);
        chk("R8 no rsp", 32'(rsp_valid), 32'd0);
        chk("R8 words", words_req, m_words);
        @(negedge clk);
        chk("R8 no rsp later", 32'(rsp_valid), 32'd0);
    endtask

    task automatic write_slot(input int l, input int e, input logic [15:0] v);
        @(negedge clk);
        tbl_we   = 1'b1;
        tbl_line = 6'(l);
        tbl_elem = 1'(e);
        tbl_addr = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        do_reset();
        for (int l = 0; l < LINES; l++) begin
            for (int e = 0; e < LE; e++) write_slot(l, e, BASE + 16'(2 * l + e));
        end
        skip_req();
        for (int i = 0; i < 128; i++) begin
            serve(BASE + 16'(i));
            if (i % 16 == 7) skip_req();
        end
        for (int i = 127; i >= 0; i--) serve(BASE + 16'(i));
        for (int k = 0; k < 128; k++) serve(BASE + 16'((k * 37) % 128));
        write_slot(5, 1, SPECIAL);
        serve(BASE + 16'(120));
        serve(SPECIAL); // R11
        do_reset();
        serve(BASE + 16'(4));
        serve(BASE + 16'(100));
        serve(SPECIAL); // R11 survives reset
        do_reset();
        serve(BASE + 16'(110));
        for (int k = 0; k < 64; k++) serve(BASE + 16'((k * 53 + 1) % 128 == 11 ? 12 : (k * 53 + 1) % 128));
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule